// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Controller

This block is the interrupt priority logic of one peripheral in a chain of identical peripherals. Each device in the chain receives an enable from the device above it (`iei`) and passes an enable to the device below it (`ieo`). The device nearest the CPU has its `iei` tied high, so position in the chain is the only thing that sets priority. Inside the device there are `NPORTS` request sources. Source 0 has the highest internal priority, and each source's enable-in is the enable-out of the source above it.

Software programs each source through control-word writes. One control word loads the upper vector bits. Another control word stages an enable bit, and that enable only takes effect at the end of the next ordinary opcode fetch. An enabled, pending source pulls the shared active-low interrupt line when its chain enable is high. The CPU acknowledges with `m1_n` and `iorq_n` low together. The granted source then drives its 8-bit vector and becomes under service. A source under service blocks every lower source and device until the CPU fetches the two-byte return-from-interrupt opcode (0xED then 0x4D) while that source's enable-in is high. A higher source may still nest over a source that is under service.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset, `int_n` is 1, `vec_oe` is 0, no source is enabled, pending or under service, and `ieo` equals `iei`.
- R2: A write on `ctl_wr[i]` with `cpu_data[0]`=0 loads `cpu_data[7:1]` as vector bits 7:1 of source i. Vector bit 0 is always driven as 0.
- R3: A write on `ctl_wr[i]` with `cpu_data[3:0]`=4'b0111 stages enable bit `cpu_data[7]`. The staged value takes effect in the cycle after the first rising edge of `m1_n` that ends a fetch without an acknowledge. Acknowledge M1 cycles do not apply it.
- R4: When `iei` is 0, `int_n` is 1 and `ieo` is 0. When `iei` is 1 and an enabled, pending source is not under service and no source above it is under service, `int_n` is 0.
- R5: Acknowledge is `m1_n`=0 and `iorq_n`=0. The winning source drives `vec_oe`=1 and its vector on `vec_data` from the second acknowledge cycle until the acknowledge ends. At all other times `vec_oe` is 0.
- R6: During an acknowledge, any enabled, pending source forces the enable-out to every lower source and to `ieo` low.
- R7: When the acknowledge ends, the winner's pending flag clears and it becomes under service. While it is under service, `ieo` stays 0 and lower sources cannot interrupt.
- R8: If several sources are pending, the lowest-indexed one wins. A higher source may request, be acknowledged and nest while a lower source is under service.
- R9: Fetching 0xED then 0x4D on consecutive non-acknowledge M1 cycles clears the under-service flag of the highest source that is under service and has its enable-in high. Any other byte between the two cancels the sequence.
- R10: From the end of a fetch of 0xED until the end of the next fetch, an enabled, pending source forces `ieo` low.
- R11: A return-from-interrupt fetched while `iei` is 0 leaves the under-service state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m1_n | input | 1 | CPU machine-cycle-one, active low |
| iorq_n | input | 1 | CPU I/O request, active low |
| cpu_data | input | DW | CPU data bus: opcode during fetch, control word during writes |
| ctl_wr | input | NPORTS | Per-source control-word write strobe |
| req | input | NPORTS | Per-source interrupt request pulse |
| iei | input | 1 | Chain enable from the higher-priority device |
| ieo | output | 1 | Chain enable to the lower-priority device |
| int_n | output | 1 | Interrupt request, 0 = pull line low, 1 = release |
| vec_oe | output | 1 | Vector drive enable during acknowledge |
| vec_data | output | DW | Vector of the granted source |

## Verification
The hardest state to reach is a nested service: a lower source is already under service, a higher source then interrupts, and the two return opcodes must unwind the services one level at a time. The bench first acknowledges source 1 and then requests source 0. It checks both vectors, then issues two return sequences and checks `ieo` after each. A sweep over every combination of `iei`, per-source enable and per-source request runs a full request, acknowledge and return sequence for each combination. The expected winner, vector and chain levels are computed arithmetically. The delayed enable is tested against an intervening acknowledge M1. The interrupted 0xED, 0x00, 0x4D sequence is also covered.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

  localparam logic [7:0] OP_PREFIX_ED = 8'hED;
  localparam logic [7:0] OP_RETURN_4D = 8'h4D;
  localparam logic [3:0] CTL_INT_NIB  = 4'b0111;

  typedef struct packed {
    logic ack;
    logic ack_start;
    logic ack_end;
    logic fetch_end;
    logic reti;
    logic ed_seen;
  } cyc_evt_t;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/irq_cycle_mon.sv
module irq_cycle_mon
  import irq_chain_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m1_n,
  input  logic          iorq_n,
  input  logic [DW-1:0] cpu_data,
  output cyc_evt_t      evt
);

  logic          m1_q, m1_d;
  logic          ack_q, ack_d;
  logic          had_ack_q, had_ack_d;
  logic [DW-1:0] op_q, op_d;
  logic          ed_q, ed_d;

  logic ack, m1_low, m1_end, fetch_end;

  // Decode of the current bus cycle
  always_comb begin
    m1_low    = ~m1_n;
    ack       = m1_low & ~iorq_n;
    m1_end    = m1_q & ~m1_low;
    fetch_end = m1_end & ~had_ack_q;
  end

  // Next state
  always_comb begin
    m1_d      = m1_low;
    ack_d     = ack;
    had_ack_d = m1_low ? (had_ack_q | ack) : 1'b0;
    op_d      = (m1_low & iorq_n) ? cpu_data : op_q;
    ed_d      = ed_q;
    if (fetch_end) ed_d = (op_q[7:0] == OP_PREFIX_ED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_q      <= 1'b0;
      ack_q     <= 1'b0;
      had_ack_q <= 1'b0;
      op_q      <= '0;
      ed_q      <= 1'b0;
    end else begin
      m1_q      <= m1_d;
      ack_q     <= ack_d;
      had_ack_q <= had_ack_d;
      op_q      <= op_d;
      ed_q      <= ed_d;
    end
  end

  always_comb begin
    evt.ack       = ack;
    evt.ack_start = ack & ~ack_q;
    evt.ack_end   = ~ack & ack_q;
    evt.fetch_end = fetch_end;
    evt.reti      = fetch_end & ed_q & (op_q[7:0] == OP_RETURN_4D);
    evt.ed_seen   = ed_q;
  end

endmodule

// File: rtl/irq_port_slot.sv
module irq_port_slot
  import irq_chain_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iei,
  input  logic          req,
  input  logic          ctl_wr,
  input  logic [DW-1:0] wdata,
  input  cyc_evt_t      evt,
  output logic          ieo,
  output logic          irq,
  output logic          drive,
  output logic          gnt,
  output logic [DW-1:0] vec
);

  logic [DW-2:0] vec_hi_q, vec_hi_d;
  logic          en_q, en_d;
  logic          stage_q, stage_d;
  logic          upd_q, upd_d;
  logic          pend_q, pend_d;
  logic          serv_q, serv_d;
  logic          gnt_q, gnt_d;
  logic          active, win;

  always_comb begin
    active = pend_q & en_q;
    win    = evt.ack_start & iei & active & ~serv_q & ~gnt_q;
  end

  // Next state
  always_comb begin
    vec_hi_d = vec_hi_q;
    en_d     = en_q;
    stage_d  = stage_q;
    upd_d    = upd_q;
    pend_d   = pend_q;
    serv_d   = serv_q;
    gnt_d    = gnt_q;

    if (ctl_wr && !wdata[0]) vec_hi_d = wdata[DW-1:1];

    if (evt.fetch_end && upd_q) begin
      en_d  = stage_q;
      upd_d = 1'b0;
    end
    if (ctl_wr && (wdata[3:0] == CTL_INT_NIB)) begin
      stage_d = wdata[DW-1];
      upd_d   = 1'b1;
    end

    if (win)         gnt_d = 1'b1;
    if (evt.ack_end) gnt_d = 1'b0;

    if (evt.ack_end && gnt_q) pend_d = 1'b0;
    if (req)                  pend_d = 1'b1;

    if (evt.reti && iei)      serv_d = 1'b0;
    if (evt.ack_end && gnt_q) serv_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_hi_q <= '0;
      en_q     <= 1'b0;
      stage_q  <= 1'b0;
      upd_q    <= 1'b0;
      pend_q   <= 1'b0;
      serv_q   <= 1'b0;
      gnt_q    <= 1'b0;
    end else begin
      vec_hi_q <= vec_hi_d;
      en_q     <= en_d;
      stage_q  <= stage_d;
      upd_q    <= upd_d;
      pend_q   <= pend_d;
      serv_q   <= serv_d;
      gnt_q    <= gnt_d;
    end
  end

  // Chain and bus outputs
  always_comb begin
    ieo   = iei & ~serv_q & ~(active & (evt.ack | evt.ed_seen));
    irq   = iei & active & ~serv_q;
    drive = gnt_q & evt.ack;
    gnt   = gnt_q;
    vec   = {vec_hi_q, 1'b0};
  end

endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
  import irq_chain_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m1_n,
  input  logic              iorq_n,
  input  logic [DW-1:0]     cpu_data,
  input  logic [NPORTS-1:0] ctl_wr,
  input  logic [NPORTS-1:0] req,
  input  logic              iei,
  output logic              ieo,
  output logic              int_n,
  output logic              vec_oe,
  output logic [DW-1:0]     vec_data
);

  logic              rst_sync_n;
  cyc_evt_t          evt;
  logic [NPORTS:0]   chain;
  logic [NPORTS-1:0] irq_v, drive_v, gnt;
  logic [DW-1:0]     vec_v [NPORTS];

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_cycle_mon #(.DW(DW)) u_mon (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .m1_n     (m1_n),
    .iorq_n   (iorq_n),
    .cpu_data (cpu_data),
    .evt      (evt)
  );

  assign chain[0] = iei;

  for (genvar i = 0; i < NPORTS; i++) begin : g_slot
    irq_port_slot #(.DW(DW)) u_slot (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .iei    (chain[i]),
      .req    (req[i]),
      .ctl_wr (ctl_wr[i]),
      .wdata  (cpu_data),
      .evt    (evt),
      .ieo    (chain[i+1]),
      .irq    (irq_v[i]),
      .drive  (drive_v[i]),
      .gnt    (gnt[i]),
      .vec    (vec_v[i])
    );
  end

  always_comb begin
    vec_data = '0;
    for (int i = 0; i < NPORTS; i++)
      if (drive_v[i]) vec_data = vec_data | vec_v[i];
  end

  assign ieo    = chain[NPORTS];
  assign int_n  = ~|irq_v;
  assign vec_oe = |drive_v;

endmodule

// File: rtl/irq_chain_checker.sv
module irq_chain_checker #(
  parameter int NPORTS = 2,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m1_n,
  input logic              iorq_n,
  input logic              iei,
  input logic              ieo,
  input logic              int_n,
  input logic              vec_oe,
  input logic [DW-1:0]     vec_data,
  input logic [NPORTS-1:0] gnt
);

  assert_vec_only_in_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (!m1_n && !iorq_n));

  assert_vec_winner_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (iei && !ieo));

  assert_vec_bit0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> !vec_data[0]);

  assert_blocked_by_iei_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !iei |-> (int_n && !ieo));

  assert_serv_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_oe && (m1_n || iorq_n) === 1'b0 ? 1'b0 : $fell(vec_oe)) |=> !ieo);

  assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

endmodule

bind irq_chain_ctrl irq_chain_checker #(.NPORTS(NPORTS), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .m1_n     (m1_n),
  .iorq_n   (iorq_n),
  .iei      (iei),
  .ieo      (ieo),
  .int_n    (int_n),
  .vec_oe   (vec_oe),
  .vec_data (vec_data),
  .gnt      (gnt)
);

// File: tb/irq_chain_ctrl_tb.sv
module irq_chain_ctrl_tb;

  localparam int NP = 2;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          m1_n, iorq_n, iei;
  logic [DW-1:0] cpu_data;
  logic [NP-1:0] ctl_wr, req;
  logic          ieo, int_n, vec_oe;
  logic [DW-1:0] vec_data;

  int checks;
  int errors;

  irq_chain_ctrl #(.NPORTS(NP), .DW(DW)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .m1_n     (m1_n),
    .iorq_n   (iorq_n),
    .cpu_data (cpu_data),
    .ctl_wr   (ctl_wr),
    .req      (req),
    .iei      (iei),
    .ieo      (ieo),
    .int_n    (int_n),
    .vec_oe   (vec_oe),
    .vec_data (vec_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; m1_n = 1'b1; iorq_n = 1'b1; cpu_data = '0;
    ctl_wr = '0; req = '0;
    step(2);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic ctl_write(input int p, input logic [7:0] d);
    cpu_data = d; ctl_wr[p] = 1'b1;
    step(1);
    ctl_wr = '0; cpu_data = '0;
  endtask

  task automatic fetch(input logic [7:0] op);
    cpu_data = op; m1_n = 1'b0;
    step(2);
    m1_n = 1'b1; cpu_data = '0;
    step(2);
  endtask

  task automatic pulse_req(input logic [NP-1:0] r);
    req = r;
    step(1);
    req = '0;
  endtask

  // Acknowledge cycle; returns ieo in the first ack cycle and the vector outputs one cycle later
  task automatic ack_cycle(output logic ieo_first, output logic oe, output logic [7:0] v);
    m1_n = 1'b0;
    step(1);
    iorq_n = 1'b0;
    @(negedge clk); ieo_first = ieo;
    @(posedge clk); #2;
    @(negedge clk); oe = vec_oe; v = vec_data;
    @(posedge clk); #2;
    m1_n = 1'b1; iorq_n = 1'b1;
    step(2);
  endtask

  task automatic set_enable(input int p, input logic en);
    ctl_write(p, {en, 3'b000, 4'b0111});
  endtask

  initial begin : watchdog
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic f_ieo, f_oe;
    logic [7:0] f_vec;
    checks = 0; errors = 0;
    iei = 1'b1;
    do_reset();

    // R1 reset state
    @(negedge clk);
    chk("R1 int_n", {7'd0, int_n}, 8'd1);
    chk("R1 vec_oe", {7'd0, vec_oe}, 8'd0);
    chk("R1 ieo follows iei=1", {7'd0, ieo}, 8'd1);
    iei = 1'b0;
    @(negedge clk);
    chk("R1 ieo follows iei=0", {7'd0, ieo}, 8'd0);
    iei = 1'b1;
    step(1);

    // Sweep: iei, enables and requests of both sources (R2 R4 R5 R6 R7 R8 R9)
    for (int k = 0; k < 32; k++) begin
      logic s_iei, ea, eb, pa, pb, ra, rb, win_a, any;
      logic [7:0] va, vb;
      s_iei = k[4]; ea = k[3]; eb = k[2]; pa = k[1]; pb = k[0];
      ra = ea & pa; rb = eb & pb; any = ra | rb; win_a = ra;
      va = 8'(8'h80 | (k << 1));
      vb = 8'(8'h40 + (k << 1));
      iei = 1'b1;
      do_reset();
      ctl_write(0, va);
      ctl_write(1, vb);
      set_enable(0, ea);
      set_enable(1, eb);
      fetch(8'h00);
      pulse_req({pb, pa});
      iei = s_iei;
      step(1);
      @(negedge clk);
      chk($sformatf("R4 sweep%0d int_n", k), {7'd0, int_n}, {7'd0, ~(s_iei & any)});
      chk($sformatf("R5 sweep%0d idle vec_oe", k), {7'd0, vec_oe}, 8'd0);
      step(1);
      ack_cycle(f_ieo, f_oe, f_vec);
      chk($sformatf("R6 sweep%0d ieo in ack", k), {7'd0, f_ieo}, {7'd0, s_iei & ~any});
      chk($sformatf("R5 sweep%0d vec_oe", k), {7'd0, f_oe}, {7'd0, s_iei & any});
      if (s_iei & any)
        chk($sformatf("R8 R2 sweep%0d vector", k), f_vec, win_a ? va : vb);
      @(negedge clk);
      chk($sformatf("R7 sweep%0d ieo after ack", k), {7'd0, ieo}, {7'd0, s_iei & ~any});
      chk($sformatf("R7 sweep%0d int_n after ack", k), {7'd0, int_n}, 8'd1);
      step(1);
      fetch(8'hED);
      fetch(8'h4D);
      @(negedge clk);
      chk($sformatf("R9 sweep%0d ieo after return", k), {7'd0, ieo}, {7'd0, s_iei});
      chk($sformatf("R9 sweep%0d int_n after return", k), {7'd0, int_n},
          {7'd0, ~(s_iei & any & win_a & rb)});
      step(1);
    end

    // R3 delayed enable, acknowledge M1 does not apply it
    iei = 1'b1;
    do_reset();
    ctl_write(0, 8'h22);
    set_enable(0, 1'b1);
    pulse_req(2'b01);
    @(negedge clk);
    chk("R3 not yet enabled", {7'd0, int_n}, 8'd1);
    step(1);
    ack_cycle(f_ieo, f_oe, f_vec);
    chk("R3 no grant before enable", {7'd0, f_oe}, 8'd0);
    @(negedge clk);
    chk("R3 ack M1 does not enable", {7'd0, int_n}, 8'd1);
    step(1);
    fetch(8'h00);
    @(negedge clk);
    chk("R3 enabled after fetch", {7'd0, int_n}, 8'd0);
    step(1);
    set_enable(0, 1'b0);
    @(negedge clk);
    chk("R3 disable staged", {7'd0, int_n}, 8'd0);
    step(1);
    fetch(8'h00);
    @(negedge clk);
    chk("R3 disabled after fetch", {7'd0, int_n}, 8'd1);
    step(1);

    // R10 prefix hazard on a pending request
    set_enable(0, 1'b1);
    fetch(8'h00);
    @(negedge clk);
    chk("R10 ieo before prefix", {7'd0, ieo}, 8'd1);
    step(1);
    fetch(8'hED);
    @(negedge clk);
    chk("R10 ieo low after prefix", {7'd0, ieo}, 8'd0);
    step(1);
    fetch(8'h00);
    @(negedge clk);
    chk("R10 ieo restored", {7'd0, ieo}, 8'd1);
    step(1);

    // R9 broken sequence and R11 return with iei low
    ack_cycle(f_ieo, f_oe, f_vec);
    chk("R2 vector source 0", f_vec, 8'h22);
    fetch(8'hED);
    fetch(8'h00);
    fetch(8'h4D);
    @(negedge clk);
    chk("R9 broken sequence keeps service", {7'd0, ieo}, 8'd0);
    step(1);
    iei = 1'b0;
    fetch(8'hED);
    fetch(8'h4D);
    iei = 1'b1;
    @(negedge clk);
    chk("R11 return with iei low ignored", {7'd0, ieo}, 8'd0);
    step(1);
    fetch(8'hED);
    fetch(8'h4D);
    @(negedge clk);
    chk("R9 return clears service", {7'd0, ieo}, 8'd1);
    step(1);

    // R8 nesting: source 0 over source 1 under service
    do_reset();
    ctl_write(0, 8'h60);
    ctl_write(1, 8'h70);
    set_enable(0, 1'b1);
    set_enable(1, 1'b1);
    fetch(8'h00);
    pulse_req(2'b10);
    ack_cycle(f_ieo, f_oe, f_vec);
    chk("R8 lower vector", f_vec, 8'h70);
    pulse_req(2'b01);
    @(negedge clk);
    chk("R8 higher interrupts over service", {7'd0, int_n}, 8'd0);
    step(1);
    ack_cycle(f_ieo, f_oe, f_vec);
    chk("R8 nested vector", f_vec, 8'h60);
    fetch(8'hED);
    fetch(8'h4D);
    @(negedge clk);
    chk("R8 lower still in service", {7'd0, ieo}, 8'd0);
    step(1);
    fetch(8'hED);
    fetch(8'h4D);
    @(negedge clk);
    chk("R8 all services ended", {7'd0, ieo}, 8'd1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule